// File: doc/BRIEF.md
# Synchronized Four-Channel DAC Updater

This block holds the set-points for four 12-bit DAC channels behind a small 16-bit register bus. Each channel register is a shadow copy: ordinary writes change only the value held inside the block, so software can prepare any mix of channels without disturbing the analogue outputs. When a write carries its top bit set, the block stores that write's code and then ships all four shadow values, one after another, to an external serial DAC over an SPI-style link. It finishes with a load strobe so that every output moves at the same instant.

While the transfer runs, the top bit of every channel register reads back as a busy flag. Writes that arrive during that window are dropped, so a transfer in flight always carries the values that were current when it was committed. With the default divider, the full four-frame update fits in roughly 3 microseconds at a 50 MHz system clock.

Top module: `dac_sync_bank`

## Requirements
- R1: After reset all four shadow codes are zero, every channel register reads 0x0000, `dac_cs_n` and `dac_load_n` are high and `dac_sclk` is low.
- R2: Channel k (k = 0..3) sits at byte address 0xA0 + 2k. A read returns {busy, 3'b000, code[11:0]} one cycle after the address is presented. Any other address reads 0x0000, and writes to it change nothing.
- R3: A write with bit 15 clear updates only the addressed shadow code. No serial activity follows: `dac_cs_n` stays high and no frame is sent.
- R4: A write with bit 15 set to any channel register first stores its code, then sends all four channel codes, with the new code included.
- R5: Each channel goes out as one 16-bit frame, MSB first, laid out as {channel[1:0], 2'b01, code[11:0]}. Data is valid on the rising edge of `dac_sclk` while `dac_cs_n` is low. Frames go in channel order 0, 1, 2, 3, `dac_cs_n` returns high between frames, and `dac_sclk` is low whenever `dac_cs_n` is high.
- R6: After the fourth frame, `dac_load_n` pulses low exactly once per update, with `dac_cs_n` high for the whole pulse.
- R7: A commit sends the full four-frame update even when no code has changed since the previous one.
- R8: Bit 15 reads as 1 from the cycle after a committing write until the load pulse has ended, and as 0 afterwards. With default parameters the whole update takes at most 150 clock cycles.
- R9: Any write made while busy is ignored. The shadow codes stay unchanged and the update in progress sends exactly the values it started with, with no extra frame or load pulse.
- R10: Bits 14:12 of write data are discarded and always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 16 | Write data; bit 15 requests a commit |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_mosi | output | 1 | Serial data to the DAC |
| dac_cs_n | output | 1 | Active-low frame select |
| dac_load_n | output | 1 | Active-low strobe that updates all DAC outputs together |

## Verification
Two functions can fall in the same cycle. The first is a bus write to a shadow register, and the second is the start of a serial update that must read those shadows. The bench provokes this in two ways. It commits through a channel whose code changes in the same write, and it issues further plain and committing writes in the cycles right after a commit, while the start is still pending and while frames are being shifted. It judges the outcome by decoding every frame seen on the serial pins against a model of the register contents, by counting frames and load pulses per update, and by reading the registers back once the busy bit has cleared.

// File: rtl/dac_sync_pkg.sv
package dac_sync_pkg;
  // serial engine phases
  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_BITS = 2'd1,
    SH_GAP  = 2'd2,
    SH_LOAD = 2'd3
  } shift_state_t;

  // control field placed between channel number and code in every frame
  localparam logic [1:0] FRAME_CTRL = 2'b01;
endpackage

// File: rtl/dac_shadow_regs.sv
module dac_shadow_regs #(
  parameter int          NCH    = 4,
  parameter int          CODE_W = 12,
  parameter int          AW     = 8,
  parameter logic [7:0]  BASE   = 8'hA0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [AW-1:0]         addr,
  input  logic [15:0]           wdata,
  input  logic                  eng_busy,
  output logic [NCH*CODE_W-1:0] shadow_flat,
  output logic                  commit,
  output logic [15:0]           rdata
);
  localparam int            CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [AW-1:0] SPAN   = AW'(2 * NCH);

  logic [CODE_W-1:0] shadow [NCH];
  logic [AW-1:0]     offset;
  logic              hit;
  logic [CH_W-1:0]   idx;
  logic              busy_any;
  logic              unused_bits;

  assign offset      = addr - BASE_A;
  assign hit         = (addr >= BASE_A) && (offset < SPAN) && !addr[0];
  assign idx         = offset[CH_W:1];
  assign busy_any    = eng_busy | commit;
  assign unused_bits = ^wdata[14:CODE_W];

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign shadow_flat[g*CODE_W +: CODE_W] = shadow[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) shadow[i] <= '0;
      commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (wr && hit && !busy_any) begin
        shadow[idx] <= wdata[CODE_W-1:0];
        commit      <= wdata[15];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (hit) begin
        rdata[CODE_W-1:0] <= shadow[idx];
        rdata[15]         <= busy_any;
      end
    end
  end
endmodule

// File: rtl/dac_serial_shifter.sv
module dac_serial_shifter
  import dac_sync_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int FRAME_W = 16,
  parameter int HALF    = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [NCH*FRAME_W-1:0] frames,
  output logic                   sclk,
  output logic                   mosi,
  output logic                   cs_n,
  output logic                   load_n,
  output logic                   busy
);
  localparam int TOT_W = NCH * FRAME_W;
  localparam int HW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW    = $clog2(FRAME_W);
  localparam int FW    = (NCH > 1) ? $clog2(NCH) : 1;

  shift_state_t     state;
  logic [TOT_W-1:0] sreg;
  logic [HW-1:0]    hcnt;
  logic [BW-1:0]    bcnt;
  logic [FW-1:0]    fcnt;
  logic             tick;

  assign tick = (hcnt == HW'(HALF - 1));
  assign busy = (state != SH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SH_IDLE;
      sreg   <= '0;
      hcnt   <= '0;
      bcnt   <= '0;
      fcnt   <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      cs_n   <= 1'b1;
      load_n <= 1'b1;
    end else begin
      if (state == SH_IDLE) hcnt <= '0;
      else if (tick)        hcnt <= '0;
      else                  hcnt <= hcnt + 1'b1;

      unique case (state)
        SH_IDLE: if (start) begin
          sreg  <= frames;
          mosi  <= frames[TOT_W-1];
          cs_n  <= 1'b0;
          sclk  <= 1'b0;
          bcnt  <= '0;
          fcnt  <= '0;
          state <= SH_BITS;
        end
        SH_BITS: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
          end else begin
            sclk <= 1'b0;
            sreg <= {sreg[TOT_W-2:0], 1'b0};
            if (bcnt == BW'(FRAME_W - 1)) begin
              cs_n  <= 1'b1;
              state <= SH_GAP;
            end else begin
              bcnt <= bcnt + 1'b1;
              mosi <= sreg[TOT_W-2];
            end
          end
        end
        SH_GAP: if (tick) begin
          if (fcnt == FW'(NCH - 1)) begin
            load_n <= 1'b0;
            state  <= SH_LOAD;
          end else begin
            fcnt  <= fcnt + 1'b1;
            bcnt  <= '0;
            cs_n  <= 1'b0;
            mosi  <= sreg[TOT_W-1];
            state <= SH_BITS;
          end
        end
        SH_LOAD: if (tick) begin
          load_n <= 1'b1;
          state  <= SH_IDLE;
        end
        default: state <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_sync_bank.sv
module dac_sync_bank
  import dac_sync_pkg::*;
#(
  parameter int         NCH      = 4,
  parameter int         CODE_W   = 12,
  parameter int         AW       = 8,
  parameter logic [7:0] BASE     = 8'hA0,
  parameter int         SCK_HALF = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          dac_sclk,
  output logic          dac_mosi,
  output logic          dac_cs_n,
  output logic          dac_load_n
);
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int FRAME_W = CH_W + 2 + CODE_W;

  logic [NCH*CODE_W-1:0]  shadow_flat;
  logic [NCH*FRAME_W-1:0] frames;
  logic                   commit;
  logic                   eng_busy;
  logic                   busy_any;

  assign busy_any = commit | eng_busy;

  // channel 0 occupies the most significant frame so it leaves first
  for (genvar g = 0; g < NCH; g++) begin : g_frame
    assign frames[(NCH-1-g)*FRAME_W +: FRAME_W] =
      {CH_W'(g), FRAME_CTRL, shadow_flat[g*CODE_W +: CODE_W]};
  end

  dac_shadow_regs #(
    .NCH(NCH), .CODE_W(CODE_W), .AW(AW), .BASE(BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .eng_busy(eng_busy), .shadow_flat(shadow_flat), .commit(commit),
    .rdata(bus_rdata)
  );

  dac_serial_shifter #(
    .NCH(NCH), .FRAME_W(FRAME_W), .HALF(SCK_HALF)
  ) u_shift (
    .clk(clk), .rst(rst), .start(commit), .frames(frames),
    .sclk(dac_sclk), .mosi(dac_mosi), .cs_n(dac_cs_n), .load_n(dac_load_n),
    .busy(eng_busy)
  );
endmodule

// File: rtl/dac_sync_checker.sv
module dac_sync_checker #(
  parameter int         NCH    = 4,
  parameter int         CODE_W = 12,
  parameter int         AW     = 8,
  parameter logic [7:0] BASE   = 8'hA0,
  parameter int         LIMIT  = 150
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic [AW-1:0]         bus_addr,
  input logic [15:0]           bus_wdata,
  input logic                  busy,
  input logic [NCH*CODE_W-1:0] shadow_flat,
  input logic                  dac_sclk,
  input logic                  dac_cs_n,
  input logic                  dac_load_n
);
  logic [15:0] busy_len;
  logic        sel;

  assign sel = (bus_addr >= AW'(BASE)) && (bus_addr < AW'(BASE + 2*NCH)) && !bus_addr[0];

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= '0;
    else if (busy_len != 16'hFFFF) busy_len <= busy_len + 1'b1;
  end

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dac_cs_n && dac_load_n && !dac_sclk));

  p_commit_starts_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel && bus_wdata[15] && !busy) |=> busy);

  p_sclk_parked_r5: assert property (@(posedge clk) disable iff (rst)
    dac_cs_n |-> !dac_sclk);

  p_load_outside_frame_r6: assert property (@(posedge clk) disable iff (rst)
    !dac_load_n |-> dac_cs_n);

  p_busy_window_r8: assert property (@(posedge clk) disable iff (rst)
    busy_len <= 16'(LIMIT));

  p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr) |=> $stable(shadow_flat));
endmodule

bind dac_sync_bank dac_sync_checker #(
  .NCH(NCH), .CODE_W(CODE_W), .AW(AW), .BASE(BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy_any), .shadow_flat(shadow_flat),
  .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_load_n(dac_load_n)
);

// File: tb/tb_dac_sync_bank.sv
module tb_dac_sync_bank;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        dac_sclk, dac_mosi, dac_cs_n, dac_load_n;

  always #(CYC/2) clk = ~clk;

  dac_sync_bank dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dac_sclk(dac_sclk),
    .dac_mosi(dac_mosi), .dac_cs_n(dac_cs_n), .dac_load_n(dac_load_n)
  );

  int checks = 0;
  int fails  = 0;
  logic [11:0] model [4];

  // serial monitor
  logic [15:0] cap [16];
  logic [15:0] cur;
  int ncap = 0, nbit = 0, nload = 0;
  always @(posedge dac_sclk) if (!dac_cs_n) begin cur = {cur[14:0], dac_mosi}; nbit++; end
  always @(posedge dac_cs_n) if (nbit > 0) begin
    if (ncap < 16) cap[ncap] = cur;
    ncap++; nbit = 0;
  end
  always @(negedge dac_load_n) nload++;

  // {addr, data} plain writes
  localparam logic [23:0] VEC [6] = '{
    {8'hA0, 16'h0123}, {8'hA2, 16'h0FFF}, {8'hA4, 16'h7800},
    {8'hA6, 16'h0A5A}, {8'hA8, 16'h0777}, {8'hA3, 16'h0333}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic wait_idle(output int polls);
    logic [15:0] d;
    polls = 0;
    do begin bus_read(8'hA0, d); polls++; end while (d[15] && polls < 1000);
  endtask

  task automatic check_update(input string req);
    check(ncap == 4, req, ncap, 4);
    check(nload == 1, req, nload, 1);
    for (int c = 0; c < 4; c++) begin
      logic [15:0] e;
      e = {c[1:0], 2'b01, model[c]};
      check(cap[c] == e, req, cap[c], e);
    end
  endtask

  initial begin
    #(CYC * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int polls;
    bus_wr = 0; bus_addr = 8'hA0; bus_wdata = 0; rst = 1'b1;
    for (int c = 0; c < 4; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(dac_cs_n && dac_load_n && !dac_sclk, "R1 pins", {dac_cs_n, dac_load_n, dac_sclk}, 3'b110);
    for (int c = 0; c < 4; c++) begin
      bus_read(8'hA0 + 8'(2*c), d);
      check(d == 16'h0, "R1 reg", d, 0);
    end

    // table of plain writes: R2, R3, R10
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a; logic [15:0] w; logic [15:0] e;
      a = VEC[i][23:16]; w = VEC[i][15:0];
      bus_write(a, w);
      if (a >= 8'hA0 && a <= 8'hA6 && !a[0]) begin
        model[(a - 8'hA0) >> 1] = w[11:0];
        e = {4'h0, w[11:0]};
      end else e = 16'h0;
      bus_read(a, d);
      check(d == e, "R2/R10 readback", d, e);
    end
    for (int c = 0; c < 4; c++) begin
      bus_read(8'hA0 + 8'(2*c), d);
      check(d == {4'h0, model[c]}, "R2 other addr no effect", d, {4'h0, model[c]});
    end
    check(ncap == 0 && nload == 0 && dac_cs_n, "R3 no serial", ncap, 0);

    // R4 commit through channel 2 with a new code; R8 busy visible at once
    ncap = 0; nload = 0;
    bus_write(8'hA4, 16'h8456); model[2] = 12'h456;
    bus_read(8'hA0, d);
    check(d[15] == 1'b1, "R8 busy after commit", d, {1'b1, 3'b0, model[0]});
    wait_idle(polls);
    check(polls < 150, "R8 duration", polls, 150);
    check_update("R4/R5/R6 update");
    bus_read(8'hA4, d);
    check(d == 16'h0456, "R4 stored code, R8 busy clear", d, 16'h0456);

    // R7 resend with nothing changed
    ncap = 0; nload = 0;
    bus_write(8'hA0, {4'h8, model[0]});
    wait_idle(polls);
    check_update("R7 unchanged resend");

    // R9 writes while busy (pending start and mid-shift) are dropped
    ncap = 0; nload = 0;
    bus_write(8'hA6, 16'h8111); model[3] = 12'h111;
    bus_write(8'hA2, 16'h0ABC);
    repeat (20) @(negedge clk);
    bus_write(8'hA2, 16'h8DEF);
    bus_write(8'hA0, 16'h0321);
    wait_idle(polls);
    repeat (5) @(negedge clk);
    check_update("R9 busy writes ignored");
    bus_read(8'hA2, d);
    check(d == {4'h0, model[1]}, "R9 shadow kept", d, {4'h0, model[1]});
    bus_read(8'hA0, d);
    check(d == {4'h0, model[0]}, "R9 shadow kept", d, {4'h0, model[0]});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule